// File: doc/BRIEF.md
# Cross-Domain Timer Register Update Bridge

This block places an 8-bit up-counting timer behind a small CPU-side register port and lets that timer run from either the CPU clock or a separate slow oscillator. The CPU writes three timer registers: the count, the compare value and the control byte. It can also read them, along with a status byte. When the timer runs from the oscillator, each write is parked in a CPU-side holding register. A toggle request then carries the write across to the timer clock, and a per-register busy flag in the status byte stays set until the timer domain has taken the value and its acknowledge has come back.

Software picks the timer clock with one status bit. In synchronous mode the timer runs from the CPU clock, writes land directly and no busy flag ever rises. A count read always returns the running counter. It comes back through a Gray-coded two-stage capture, so a value that is counting never reads torn. Compare and control reads return the holding copy. Compare-match and overflow events leave the block as single-cycle pulses in the CPU clock domain.

Software must not write a register while its busy flag is set. It must also rewrite all three timer registers after changing the clock select.

Top module: `tmr_xdom_bridge`

## Requirements
- R1: After reset the status byte, count, compare and control reads are all 0 and both event pulses are low.
- R2: Register select codes are 0 count, 1 compare, 2 control, 3 status. In the status byte, bit 3 is the clock select (1 = oscillator) and can be read and written. Bit 2 is count busy, bit 1 is compare busy and bit 0 is control busy. Bits 7:4 always read 0, and writes to bits 7:4 and 2:0 have no effect.
- R3: In oscillator mode, a write to count, compare or control shows its busy flag set in the status byte from the CPU cycle that follows the write edge.
- R4: With the oscillator period at least five CPU periods, every busy flag clears within 40 CPU cycles of its write. By then the written value is in the timer register, so a count written to a stopped timer reads back unchanged.
- R5: A compare or control read returns the value last written, from the cycle after the write, in either clock mode.
- R6: A count read returns the live counter. In synchronous mode two reads N CPU cycles apart differ by exactly N. In oscillator mode, with an oscillator period of five CPU periods, two reads 50 cycles apart differ by exactly 10.
- R7: In synchronous mode all busy flags stay 0, and a count write is visible on a count read within 3 cycles.
- R8: Control bit 0 enables counting. While it is 0 the counter holds its value.
- R9: cmp_pulse goes high for one CPU cycle each time the counter steps onto the compare value. ovf_pulse goes high for one CPU cycle each time it steps from 255 to 0. In synchronous mode each fires exactly twice in any 512 consecutive cycles.
- R10: In oscillator mode with a five-to-one period ratio, each pulse fires exactly twice in any 2560 consecutive CPU cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| tclk_ext | input | 1 | Slow oscillator clock |
| wr_en | input | 1 | Register write strobe, one CPU cycle per write |
| wr_sel | input | 2 | Write target: 0 count, 1 compare, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | 8 | Combinational read data |
| cmp_pulse | output | 1 | One-cycle compare-match pulse in the CPU domain |
| ovf_pulse | output | 1 | One-cycle overflow pulse in the CPU domain |

## Verification
Random compare, control and count values are written in oscillator mode, each followed by a check of the busy flag and the holding copy and then a wait for the flag to clear. This separates a missing or misrouted busy bit from a transfer that never completes. Counts written to a stopped timer and read back show whether the value crossed intact. Reads of a running counter at fixed spacing in both modes expose lost or doubled increments. Pulse counts over exactly two wrap periods in each mode tell a missed or stretched event apart from a correct one. Directed status writes with the busy bits and upper bits set confirm that those bits cannot be written.

// File: rtl/tmr_xdom_bridge.sv
module tmr_xdom_bridge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tclk_ext,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         cmp_pulse,
  output logic         ovf_pulse
);

  function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic         async_q;
  logic [W-1:0] hold_cnt, hold_cmp, hold_ctl;
  logic [2:0]   wr_hit, req_tgl, ack_c1, ack_c2, busy;
  logic [W-1:0] g1, g2;
  logic [2:0]   cmp_s, ovf_s;

  logic         tclk;
  logic [2:0]   req_t1, req_t2, ack_tgl, ld;
  logic [W-1:0] cnt_r, cmp_r, cnt_g, cnt_nx, src_cnt, src_cmp;
  logic         run_r, src_run, hit_cmp, hit_ovf, cmp_t, ovf_t;

  // bit 2 count, bit 1 compare, bit 0 control
  assign wr_hit = {wr_sel == 2'd0, wr_sel == 2'd1, wr_sel == 2'd2} & {3{wr_en}};
  assign busy   = req_tgl ^ ack_c2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_q  <= 1'b0;
      hold_cnt <= '0;
      hold_cmp <= '0;
      hold_ctl <= '0;
      req_tgl  <= '0;
      ack_c1   <= '0;
      ack_c2   <= '0;
      g1       <= '0;
      g2       <= '0;
      cmp_s    <= '0;
      ovf_s    <= '0;
    end else begin
      ack_c1 <= ack_tgl;
      ack_c2 <= ack_c1;
      g1     <= cnt_g;
      g2     <= g1;
      cmp_s  <= {cmp_s[1:0], cmp_t};
      ovf_s  <= {ovf_s[1:0], ovf_t};
      if (wr_hit[2]) hold_cnt <= wr_data;
      if (wr_hit[1]) hold_cmp <= wr_data;
      if (wr_hit[0]) hold_ctl <= wr_data;
      if (async_q) req_tgl <= req_tgl ^ wr_hit;
      if (wr_en && wr_sel == 2'd3) async_q <= wr_data[3];
    end
  end

  assign cmp_pulse = cmp_s[2] ^ cmp_s[1];
  assign ovf_pulse = ovf_s[2] ^ ovf_s[1];

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = gray2bin(g2);
      2'd1:    rd_data = hold_cmp;
      2'd2:    rd_data = hold_ctl;
      default: rd_data = {{(W-4){1'b0}}, async_q, busy};
    endcase
  end

  assign tclk    = async_q ? tclk_ext : clk;
  assign ld      = async_q ? (req_t2 ^ ack_tgl) : wr_hit;
  assign src_cnt = async_q ? hold_cnt : wr_data;
  assign src_cmp = async_q ? hold_cmp : wr_data;
  assign src_run = async_q ? hold_ctl[0] : wr_data[0];
  assign cnt_nx  = ld[2] ? src_cnt : cnt_r + {{(W-1){1'b0}}, run_r};
  assign hit_cmp = !ld[2] && run_r && (cnt_r + W'(1)) == cmp_r;
  assign hit_ovf = !ld[2] && run_r && &cnt_r;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_t1  <= '0;
      req_t2  <= '0;
      ack_tgl <= '0;
      cnt_r   <= '0;
      cnt_g   <= '0;
      cmp_r   <= '0;
      run_r   <= 1'b0;
      cmp_t   <= 1'b0;
      ovf_t   <= 1'b0;
    end else begin
      req_t1  <= req_tgl;
      req_t2  <= req_t1;
      ack_tgl <= req_t2;
      cnt_r   <= cnt_nx;
      cnt_g   <= cnt_nx ^ (cnt_nx >> 1);
      if (ld[1]) cmp_r <= src_cmp;
      if (ld[0]) run_r <= src_run;
      cmp_t   <= cmp_t ^ hit_cmp;
      ovf_t   <= ovf_t ^ hit_ovf;
    end
  end

endmodule

module tmr_xdom_bridge_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         tclk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [1:0]   rd_sel,
  input logic [W-1:0] rd_data,
  input logic         async_q,
  input logic [2:0]   busy,
  input logic         cmp_pulse,
  input logic         ovf_pulse,
  input logic         run_r,
  input logic [2:0]   ld,
  input logic [W-1:0] cnt_r
);

  // R2
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3) |-> (rd_data[W-1:4] == '0));

  // R3
  cnt_busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[2]) |-> $past(wr_en && wr_sel == 2'd0 && async_q));

  // R3
  ctl_busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> $past(wr_en && wr_sel == 2'd2 && async_q));

  // R7
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !async_q |-> (busy == 3'b000));

  // R8
  stopped_hold_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (!run_r && !ld[2]) |=> $stable(cnt_r));

  // R9
  cmp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  // R9
  ovf_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

endmodule

bind tmr_xdom_bridge tmr_xdom_bridge_chk #(.W(W)) u_chk (
  .clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .rd_data(rd_data), .async_q(async_q), .busy(busy),
  .cmp_pulse(cmp_pulse), .ovf_pulse(ovf_pulse), .run_r(run_r), .ld(ld),
  .cnt_r(cnt_r)
);

// File: tb/tmr_xdom_bridge_tb.sv
module tmr_xdom_bridge_tb;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tclk_ext = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic cmp_pulse, ovf_pulse;
  int total = 0, bad = 0;
  bit finished = 0;

  tmr_xdom_bridge #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tclk_ext(tclk_ext), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cmp_pulse(cmp_pulse), .ovf_pulse(ovf_pulse)
  );

  always #(CLK_P / 2) clk = ~clk;
  initial begin
    #2;
    forever #(CLK_P * 5 / 2) tclk_ext = ~tclk_ext;
  end

  function automatic logic [W-1:0] exp_status(input logic as, input logic [2:0] b);
    return {4'b0000, as, b};
  endfunction

  function automatic logic [2:0] busy_bit(input logic [1:0] sel);
    return (sel == 2'd0) ? 3'b100 : (sel == 2'd1) ? 3'b010 : 3'b001;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle(input string tag);
    logic [W-1:0] s;
    int n = 0;
    rd(2'd3, s);
    while (s[2:0] != 3'b000 && n < 40) begin
      @(negedge clk);
      n++;
      rd(2'd3, s);
    end
    chk(tag, {29'd0, s[2:0]}, 32'd0);
  endtask

  task automatic count_pulses(input int cycles, output int nc, output int no);
    nc = 0; no = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (cmp_pulse) nc++;
      if (ovf_pulse) no++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, a, b;
    logic [1:0] sel;
    int nc, no;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, v); chk("R1 status", v, 0);
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd1, v); chk("R1 compare", v, 0);
    rd(2'd2, v); chk("R1 control", v, 0);
    chk("R1 pulses", {cmp_pulse, ovf_pulse}, 0);

    // R2 status bits
    wr(2'd3, 8'hF7); rd(2'd3, v); chk("R2 read-only bits", v, exp_status(1'b0, 3'b000));
    wr(2'd3, 8'h08); rd(2'd3, v); chk("R2 clock select", v, exp_status(1'b1, 3'b000));
    wr(2'd3, 8'h00); rd(2'd3, v); chk("R2 clock select clear", v, 0);

    // R7 synchronous direct writes
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h40);
    rd(2'd3, v); chk("R7 no busy", v, 0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R7 direct count", v, 8'h40);
    wr(2'd1, 8'h33);
    rd(2'd1, v); chk("R5 sync compare read", v, 8'h33);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R8 sync stopped", v, 8'h40);

    // R6 synchronous running count
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R5 sync control read", v, 8'h01);
    repeat (5) @(negedge clk);
    rd(2'd0, a);
    repeat (20) @(negedge clk);
    rd(2'd0, b);
    chk("R6 sync step", b - a, 20);

    // R9 sync pulses
    count_pulses(512, nc, no);
    chk("R9 sync compare pulses", nc, 2);
    chk("R9 sync overflow pulses", no, 2);

    // switch to oscillator clock with the timer stopped
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h08);

    // R3 R4 R5 random writes in oscillator mode
    for (int i = 0; i < 24; i++) begin
      sel = 2'($urandom_range(0, 2));
      v = 8'($urandom);
      if (sel == 2'd2) v[0] = 1'b0;
      wr(sel, v);
      rd(2'd3, a);
      chk("R3 busy set", a, exp_status(1'b1, busy_bit(sel)));
      if (sel != 2'd0) begin
        rd(sel, a);
        chk("R5 holding read", a, v);
      end
      wait_idle("R4 busy clear");
      if (sel == 2'd0) begin
        repeat (3) @(negedge clk);
        rd(2'd0, a);
        chk("R4 count landed", a, v);
      end
    end

    // R10 R6 oscillator running
    wr(2'd1, 8'h80); wait_idle("R4 compare clear");
    wr(2'd0, 8'h00); wait_idle("R4 count clear");
    wr(2'd2, 8'h01); wait_idle("R4 control clear");
    count_pulses(2560, nc, no);
    chk("R10 async compare pulses", nc, 2);
    chk("R10 async overflow pulses", no, 2);
    rd(2'd0, a);
    repeat (50) @(negedge clk);
    rd(2'd0, b);
    chk("R6 async step", b - a, 10);

    // R8 stop in oscillator mode
    wr(2'd2, 8'h00); wait_idle("R4 stop clear");
    repeat (15) @(negedge clk);
    rd(2'd0, a);
    repeat (30) @(negedge clk);
    rd(2'd0, b);
    chk("R8 async stopped", b, a);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule